// File: doc/BRIEF.md
# Signed High-Word Multiply Execution Unit

This unit executes one family of 32-bit instruction words. Each word multiplies two signed 32-bit register values and keeps only the top 32 bits of the 64-bit product. Some forms also add that product to a third register, or subtract it from a third register, and some forms round before the top word is taken. The unit has its own 16-entry, 32-bit register file. A preload write port fills the register file and a peek read port inspects it, so the unit can be driven and observed without a surrounding pipeline.

An instruction word is offered with a one-cycle valid strobe while the unit is idle. A matching word starts an iterative shift-add multiplier that handles one multiplier bit per cycle. When the multiplier finishes, the unit writes the destination register and pulses `done` for one cycle, together with the destination index and the written value. A word outside the family pulses `illegal` for one cycle and changes no state. While an operation is in flight, `busy` is high and new strobes are dropped.

Top module: `mswmul_unit`

## Requirements
- R1: A word belongs to the family only when bits 27..21 equal 0111010 and bit 20 is 1. Bits 31..28 are ignored. Any other word accepted while idle pulses `illegal` for one cycle, in the cycle after acceptance. It writes no register and gives no `done`.
- R2: Operand fields are fixed by position: destination register index in bits 19..16, accumulator register index in bits 15..12, second multiplicand index in bits 11..8, first multiplicand index in bits 3..0. The sub-opcode is bits 7..4.
- R3: Sub-opcode 0001 with accumulator field 1111 writes the upper 32 bits of the signed 64-bit product of the two multiplicands.
- R4: Sub-opcode 0001 with an accumulator field other than 1111 writes the upper word of ({acc, 32'h0} + product), computed in 64 bits.
- R5: Sub-opcode 1101 writes the upper word of ({acc, 32'h0} - product), computed in 64 bits. When the accumulator field is 1111, the accumulator value is taken as zero.
- R6: Sub-opcodes 0011 and 1111 behave as 0001 and 1101 respectively, except that 0x0000_0000_8000_0000 is added to the 64-bit intermediate before the upper word is taken.
- R7: A family word whose sub-opcode is not 0001, 0011, 1101 or 1111 pulses `illegal` for one cycle and writes no register.
- R8: `done` is high for exactly one cycle, in the cycle after the destination register is written. `done_rd` and `done_data` then show the destination index and the value now readable at that index.
- R9: `instr_vld` is ignored while `busy` is high. Such a strobe writes no register and produces neither `done` nor `illegal`.
- R10: After reset, `busy`, `done` and `illegal` are low and every register reads zero.
- R11: Word 0xE750F011 writes r0 with the upper word of the signed product of r1 and r0, using no accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 32 | Instruction word |
| instr_vld | input | 1 | Instruction strobe, taken only while idle |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload register index |
| pre_data | input | 32 | Preload data |
| peek_addr | input | 4 | Inspection read index |
| peek_data | output | 32 | Register contents at `peek_addr` (combinational) |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| done_rd | output | 4 | Destination index of the completed operation |
| done_data | output | 32 | Value written by the completed operation |
| illegal | output | 1 | One-cycle pulse for a rejected word |

## Verification
A wrong iteration count or a corrupted partial product in the shift-add multiplier appears as a wrong `done_data`, or a wrong peek value, about 34 cycles after issue. A wrong sign correction shows up first with the operands 0x80000000 and 0xFFFFFFFF. A fault in the decoder or in the accept gate shows at once: a missing or doubled `illegal` pulse in the cycle after the strobe, an extra `done`, or a register that changed when it should have kept its value. Rounding and accumulator placement errors change only the low bit or the sign of the result. For that reason the bench uses operands whose product lies exactly on the rounding midpoint.

// File: rtl/mswmul_pkg.sv
// Package: shared constants and the decoded-instruction record.
// Assumes the 32-bit word layout with 4-bit register index fields.
package mswmul_pkg;
    localparam int XLEN   = 32;
    localparam int NREGS  = 16;
    localparam int RIDX_W = $clog2(NREGS);

    typedef struct packed {
        logic              fam;      // opcode bits match the family
        logic              known;    // sub-opcode is one of the four legal values
        logic              negate;   // subtract form
        logic              round;    // rounding form
        logic              use_acc;  // accumulator field is not the reserved value
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rm;
        logic [RIDX_W-1:0] rn;
    } dec_t;
endpackage

// File: rtl/mswmul_decode.sv
// Decoder: combinationally splits an instruction word into opcode match,
// sub-opcode class and register indices. Assumes 4-bit index fields.
module mswmul_decode
    import mswmul_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    logic [3:0] sub;
    logic       unused_cond;

    assign sub         = word[7:4];
    assign unused_cond = ^word[31:28];

    // Field extraction and family / sub-opcode classification.
    always_comb begin
        dec.fam     = (word[27:21] == 7'b0111010) && word[20];
        dec.known   = (sub == 4'b0001) || (sub == 4'b0011) ||
                      (sub == 4'b1101) || (sub == 4'b1111);
        dec.negate  = sub[3];
        dec.round   = sub[1];
        dec.rd      = word[19:16];
        dec.ra      = word[15:12];
        dec.rm      = word[11:8];
        dec.rn      = word[3:0];
        dec.use_acc = (word[15:12] != 4'hF);
    end
endmodule

// File: rtl/mswmul_regfile.sv
// Register file: NREGS x XLEN, reset to zero, with two write ports
// (the unit's port takes priority over preload) and NRD combinational reads.
module mswmul_regfile #(
    parameter int XW  = 32,
    parameter int NR  = 16,
    parameter int NRD = 4,
    localparam int AW = $clog2(NR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_u,
    input  logic [AW-1:0]           addr_u,
    input  logic [XW-1:0]           data_u,
    input  logic                    we_p,
    input  logic [AW-1:0]           addr_p,
    input  logic [XW-1:0]           data_p,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][XW-1:0]  rdata
);
    logic [XW-1:0] mem [NR];

    // Storage update: clear on reset, unit write wins over preload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) mem[i] <= '0;
        end else if (we_u) begin
            mem[addr_u] <= data_u;
        end else if (we_p) begin
            mem[addr_p] <= data_p;
        end
    end

    // One combinational read path per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/mswmul_iter.sv
// Iterative signed multiplier: multiplies the operand magnitudes with
// shift-add, one multiplier bit per cycle, and restores the sign at the
// end. fin pulses for one cycle when prod is valid. Assumes start comes
// only while idle.
module mswmul_iter #(
    parameter int W = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic           fin,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] mcand, acc;
    logic [W-1:0]   mplier;
    logic           neg, run;
    logic [CW-1:0]  cnt;

    function automatic logic [W-1:0] mag(input logic [W-1:0] v);
        return v[W-1] ? ('0 - v) : v;
    endfunction

    // Load on start, then one shift-add step per cycle for W cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand <= '0; acc <= '0; mplier <= '0;
            neg <= 1'b0; run <= 1'b0; fin <= 1'b0; cnt <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                mcand  <= {{W{1'b0}}, mag(opa)};
                mplier <= mag(opb);
                acc    <= '0;
                neg    <= opa[W-1] ^ opb[W-1];
                cnt    <= CW'(W);
                run    <= 1'b1;
            end else if (run) begin
                if (mplier[0]) acc <= acc + mcand;
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    // Signed product from the accumulated magnitude.
    assign prod = neg ? ('0 - acc) : acc;
endmodule

// File: rtl/mswmul_unit.sv
// Top: accepts one instruction while idle, reads the operands, runs the
// iterative multiplier, then adds or subtracts the accumulator in 64 bits,
// optionally rounds, writes the upper word back and pulses done.
// Rejected words pulse illegal. Assumes a single outstanding operation.
module mswmul_unit
    import mswmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_word,
    input  logic              instr_vld,
    input  logic              pre_we,
    input  logic [RIDX_W-1:0] pre_addr,
    input  logic [XLEN-1:0]   pre_data,
    input  logic [RIDX_W-1:0] peek_addr,
    output logic [XLEN-1:0]   peek_data,
    output logic              busy,
    output logic              done,
    output logic [RIDX_W-1:0] done_rd,
    output logic [XLEN-1:0]   done_data,
    output logic              illegal
);
    typedef enum logic {ST_IDLE, ST_MUL} st_t;

    localparam logic [2*XLEN-1:0] RND_K = {{XLEN{1'b0}}, 1'b1, {(XLEN-1){1'b0}}};

    st_t                       state;
    dec_t                      dec;
    logic [3:0][RIDX_W-1:0]    raddr;
    logic [3:0][XLEN-1:0]      rdata;
    logic                      accept, launch, fin;
    logic [2*XLEN-1:0]         prod, base, mix, rsum;
    logic [XLEN-1:0]           result, unused_lo;
    logic [RIDX_W-1:0]         op_rd;
    logic                      op_neg, op_rnd;
    logic [XLEN-1:0]           op_acc;
    logic                      done_q, ill_q;
    logic [RIDX_W-1:0]         rd_q;
    logic [XLEN-1:0]           res_q;

    mswmul_decode u_dec (.word(instr_word), .dec(dec));

    assign raddr = {peek_addr, dec.ra, dec.rm, dec.rn};

    mswmul_regfile #(.XW(XLEN), .NR(NREGS), .NRD(4)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_u(fin), .addr_u(op_rd), .data_u(result),
        .we_p(pre_we), .addr_p(pre_addr), .data_p(pre_data),
        .raddr(raddr), .rdata(rdata)
    );

    assign accept = (state == ST_IDLE) && instr_vld;
    assign launch = accept && dec.fam && dec.known;

    mswmul_iter #(.W(XLEN)) u_mul (
        .clk(clk), .rst_n(rst_n), .start(launch),
        .opa(rdata[0]), .opb(rdata[1]), .fin(fin), .prod(prod)
    );

    // Final combine: accumulator in the upper word, add or subtract, round.
    always_comb begin
        base   = {op_acc, {XLEN{1'b0}}};
        mix    = op_neg ? (base - prod) : (base + prod);
        rsum   = mix + (op_rnd ? RND_K : '0);
        result = rsum[2*XLEN-1:XLEN];
    end
    assign unused_lo = rsum[XLEN-1:0];

    // Sequencing: issue, reject or complete, and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_rd <= '0; op_neg <= 1'b0; op_rnd <= 1'b0; op_acc <= '0;
            done_q <= 1'b0; ill_q <= 1'b0; rd_q <= '0; res_q <= '0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            if (launch) begin
                state  <= ST_MUL;
                op_rd  <= dec.rd;
                op_neg <= dec.negate;
                op_rnd <= dec.round;
                op_acc <= dec.use_acc ? rdata[2] : '0;
            end else if (accept) begin
                ill_q <= 1'b1;
            end
            if (fin) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
                rd_q   <= op_rd;
                res_q  <= result;
            end
        end
    end

    assign peek_data = rdata[3];
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign done_rd   = rd_q;
    assign done_data = res_q;
    assign illegal   = ill_q;
endmodule

// File: rtl/mswmul_unit_chk.sv
// Checker: temporal rules on the unit's handshake outputs. Attached to
// every mswmul_unit instance by the bind below.
module mswmul_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_vld,
    input logic busy,
    input logic done,
    input logic illegal
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R1
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);
    // R9
    illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(instr_vld && !busy));
    // R7
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));
endmodule

bind mswmul_unit mswmul_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld),
    .busy(busy), .done(done), .illegal(illegal)
);

// File: tb/mswmul_unit_tb_top.sv
// Bench: directed corners plus seeded random operations, checked against
// a reference function and a shadow copy of the register file.
module mswmul_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr_word;
    logic        instr_vld, pre_we;
    logic [3:0]  pre_addr, peek_addr, done_rd;
    logic [31:0] pre_data, peek_data, done_data;
    logic        busy, done, illegal;

    int n_chk = 0, n_fail = 0;
    logic [31:0] model [16];

    always #2 clk = ~clk;

    mswmul_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .instr_vld(instr_vld),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .peek_addr(peek_addr), .peek_data(peek_data), .busy(busy),
        .done(done), .done_rd(done_rd), .done_data(done_data), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_val(input logic [3:0] sub, input logic [3:0] raf,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] c);
        logic signed [63:0] sa, sb, p;
        logic [63:0] base, t;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        p  = sa * sb;
        base = (raf != 4'hF) ? {c, 32'h0} : 64'h0;
        t = sub[3] ? (base - p) : (base + p);
        if (sub[1]) t = t + 64'h8000_0000;
        return t[63:32];
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] sub, input logic [3:0] rd,
                                       input logic [3:0] ra, input logic [3:0] rm,
                                       input logic [3:0] rn);
        return {4'hE, 7'b0111010, 1'b1, rd, ra, rm, sub, rn};
    endfunction

    function automatic logic [31:0] pickv();
        case ($urandom % 6)
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0;
            default: return $urandom;
        endcase
    endfunction

    task automatic preload(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
        model[a] = d;
    endtask

    task automatic peek(input logic [3:0] a, input string tag);
        peek_addr = a;
        #1;
        check(tag, peek_data, model[a]);
    endtask

    task automatic do_op(input logic [31:0] w, output logic gd, output logic gi,
                         output logic [31:0] gdata, output logic [3:0] grd);
        @(negedge clk);
        instr_word = w; instr_vld = 1'b1;
        @(negedge clk);
        instr_vld = 1'b0;
        gi = illegal; gd = done; gdata = '0; grd = '0;
        if (!gi) begin
            for (int i = 0; i < 80; i++) begin
                if (done) begin gd = 1'b1; gdata = done_data; grd = done_rd; break; end
                @(negedge clk);
            end
        end
        @(negedge clk);
        check("R8/R1 pulse ends after one cycle", {30'b0, done, illegal}, 32'h0);
    endtask

    task automatic legal_case(input logic [3:0] sub, input logic [3:0] rd, input logic [3:0] ra,
                              input logic [3:0] rm, input logic [3:0] rn,
                              input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                              input string tag);
        logic gd, gi; logic [31:0] gdata, exp; logic [3:0] grd;
        preload(rn, a);
        preload(rm, b);
        if (ra != 4'hF) preload(ra, c);
        exp = ref_val(sub, ra, model[rn], model[rm], model[ra]);
        do_op(mk(sub, rd, ra, rm, rn), gd, gi, gdata, grd);
        check({tag, " done seen"}, {31'b0, gd}, 32'h1);
        check({tag, " result"}, gdata, exp);
        check("R2 R8 done_rd", {28'b0, grd}, {28'b0, rd});
        model[rd] = exp;
        peek(rd, "R8 written value readable");
    endtask

    task automatic illegal_case(input logic [31:0] w, input logic [3:0] rd, input string tag);
        logic gd, gi; logic [31:0] gdata; logic [3:0] grd;
        do_op(w, gd, gi, gdata, grd);
        check({tag, " illegal"}, {31'b0, gi}, 32'h1);
        check({tag, " no done"}, {31'b0, gd}, 32'h0);
        peek(rd, {tag, " register kept"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic gd, gi; logic [31:0] gdata, expa; logic [3:0] grd;
        void'($urandom(32'd7));
        rst_n = 1'b0; instr_vld = 1'b0; instr_word = '0;
        pre_we = 1'b0; pre_addr = '0; pre_data = '0; peek_addr = '0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset outputs", {29'b0, busy, done, illegal}, 32'h0);
        peek(4'd7, "R10 register cleared");

        // R11 fixed example word
        preload(4'd0, 32'h0000_0006);
        preload(4'd1, 32'hC000_0000);
        expa = ref_val(4'b0001, 4'hF, model[1], model[0], 32'h0);
        do_op(32'hE750F011, gd, gi, gdata, grd);
        check("R11 example result", gdata, expa);
        check("R11 example dest", {28'b0, grd}, 32'h0);
        model[0] = expa;

        // R3 R5 R6 directed corners
        legal_case(4'b0001, 4'd2, 4'hF, 4'd3, 4'd4, 32'h8000_0000, 32'h8000_0000, 0, "R3 min*min");
        legal_case(4'b0001, 4'd2, 4'hF, 4'd3, 4'd4, 32'h0000_0001, 32'h8000_0000, 0, "R3 unrounded midpoint");
        legal_case(4'b0011, 4'd2, 4'hF, 4'd3, 4'd4, 32'h0000_0001, 32'h8000_0000, 0, "R6 rounded midpoint");
        legal_case(4'b1101, 4'd5, 4'hF, 4'd3, 4'd4, 32'h0000_0002, 32'h0000_0003, 0, "R5 subtract no acc");
        legal_case(4'b1111, 4'd5, 4'd6, 4'd3, 4'd4, 32'h0000_0001, 32'h8000_0000, 32'h10, "R6 R5 rounded subtract");
        legal_case(4'b0001, 4'd7, 4'd6, 4'd8, 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R4 accumulate wrap");

        // Random mix of all four legal forms
        for (int k = 0; k < 150; k++) begin
            logic [3:0] sub, rd, ra, rm, rn;
            logic [3:0] subs [4];
            string tag;
            subs = '{4'b0001, 4'b0011, 4'b1101, 4'b1111};
            sub = subs[$urandom % 4];
            rd = 4'($urandom); rm = 4'($urandom); rn = 4'($urandom);
            ra = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
            if (sub[3]) tag = "R5 subtract random";
            else if (ra == 4'hF) tag = "R3 plain random";
            else tag = "R4 accumulate random";
            legal_case(sub, rd, ra, rm, rn, pickv(), pickv(), pickv(), tag);
        end

        // R7 every unknown sub-opcode inside the family
        for (int s = 0; s < 16; s++) begin
            if (s == 1 || s == 3 || s == 13 || s == 15) continue;
            illegal_case(mk(4'(s), 4'd5, 4'd6, 4'd3, 4'd4), 4'd5, "R7 bad sub-opcode");
        end
        // R1 words outside the family
        illegal_case(mk(4'b0001, 4'd5, 4'hF, 4'd3, 4'd4) & ~32'h0010_0000, 4'd5, "R1 bit20 clear");
        illegal_case(mk(4'b0001, 4'd5, 4'hF, 4'd3, 4'd4) ^ 32'h0400_0000, 4'd5, "R1 opcode mismatch");
        illegal_case(32'h0, 4'd0, "R1 zero word");

        // R9 strobe while busy is dropped
        preload(4'd10, 32'h1234_5678);
        preload(4'd11, 32'h8765_4321);
        preload(4'd12, 32'hAAAA_5555);
        expa = ref_val(4'b0001, 4'hF, model[10], model[11], 32'h0);
        @(negedge clk);
        instr_word = mk(4'b0001, 4'd13, 4'hF, 4'd11, 4'd10); instr_vld = 1'b1;
        @(negedge clk);
        instr_word = mk(4'b1101, 4'd12, 4'd11, 4'd10, 4'd11);
        @(negedge clk);
        instr_word = 32'h0;
        @(negedge clk);
        check("R9 no illegal while busy", {31'b0, illegal}, 32'h0);
        instr_vld = 1'b0;
        gd = 1'b0; gdata = '0;
        for (int i = 0; i < 80; i++) begin
            if (done) begin gd = 1'b1; gdata = done_data; break; end
            @(negedge clk);
        end
        check("R9 first op result", gdata, expa);
        model[13] = expa;
        gd = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done || illegal) gd = 1'b1;
        end
        check("R9 dropped strobes gave no pulse", {31'b0, gd}, 32'h0);
        peek(4'd12, "R9 dropped target unchanged");
        peek(4'd13, "R9 first op written");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule